// File: doc/BRIEF.md
# Bank-Switching Memory Map Translator

This block sits between an 8-bit CPU with a 16-bit address bus and a 128 KB physical RAM split into two 64 KB banks. For every CPU address it produces one chip select: RAM, one of three ROM areas, the I/O window, or its own registers. For a RAM access it also gives the physical bank bit and a translated 16-bit address. Five byte-wide control registers at the top of the map set the visible configuration. They cover the CPU bank, which ROM areas and the I/O window appear, how large the shared RAM regions at both ends of the map are, where the zero page and stack page really live, and which bank and 16 KB window the video fetch unit reads.

Shared regions are always served from the bank opposite the one the CPU has selected. This gives a common scratch area that stays reachable whatever bank the CPU switches to. Address decode is combinational. Register writes take effect at the clock edge on which the write strobe is high.

Top module: `mmu_bank_map`

## Requirements
- R1: After reset the registers read back as: config ($FF00) = $3C, sharing ($FF01) = $00, zero-page page ($FF02) = $00, stack page ($FF03) = $01, video ($FF04) = $00.
- R2: Addresses $FF00–$FF04 assert reg_sel and drive cpu_rdata with the register value. A write with cpu_we high loads cpu_wdata at the next rising clock edge. Such an access never asserts ram_en. $FF05–$FFFF are ordinary RAM.
- R3: Config bits [1:0] hold the CPU block number. Only bit 0 reaches ram_bank, so blocks 2 and 3 alias blocks 0 and 1. Outside shared regions ram_bank equals that bit.
- R4: Bottom shared region: translated pages $00–$03 are always shared. With sharing bit 4 set, the region is instead 1/4/8/16 KB for sharing bits [1:0] = 0/1/2/3. A shared RAM access gets ram_bank = inverse of config bit 0.
- R5: Top shared region: translated pages $FF–$FF are always shared. With sharing bit 5 set, the region is the top 1/4/8/16 KB for sharing bits [3:2] = 0/1/2/3. Banking follows the same opposite-bank rule.
- R6: The targets are decoded in this priority: registers, then I/O, then ROM, then RAM. I/O covers $D000–$DFFF when config bit 2 is set. Low ROM covers $4000–$7FFF when bit 3 is set. Middle ROM covers $8000–$BFFF when bit 4 is set. High ROM covers $C000–$FEFF when bit 5 is set.
- R7: Exactly one of reg_sel, io_en, rom_lo_en, rom_mid_en, rom_hi_en, ram_en is high for every address.
- R8: Let Z be the zero-page register and S the stack-page register. The CPU page P translates as follows: P=0 gives Z; otherwise P=Z gives 0; otherwise P=1 gives S; otherwise P=S gives 1; otherwise P stays as it is. The low address byte is kept. Shared-region tests use the translated page.
- R9: Video register bits [1:0] select the video bank, and only bit 0 reaches vid_bank. Bits [3:2] select the 16 KB window, and vid_ram_addr = {bits[3:2], vid_addr}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Register read data, zero when no register is addressed |
| reg_sel | output | 1 | Control register addressed |
| ram_en | output | 1 | RAM selected |
| ram_bank | output | 1 | Physical RAM bank |
| ram_addr | output | 16 | Translated RAM address |
| rom_lo_en | output | 1 | Low ROM select |
| rom_mid_en | output | 1 | Middle ROM select |
| rom_hi_en | output | 1 | High ROM select |
| io_en | output | 1 | I/O window select |
| vid_addr | input | 14 | Video fetch address within its window |
| vid_bank | output | 1 | Video RAM bank |
| vid_ram_addr | output | 16 | Video address within the bank |

## Verification
Four states are hard to reach from the ports: sharing enabled at the largest size, a relocated page that lands inside a shared region, a stack page register set to zero or to the zero-page value, and block numbers 2 and 3. Each one needs a specific sequence of register writes before the address that exposes it. The stimulus therefore interleaves random register writes with random reads of addresses drawn around every region edge, such as $03FF/$0400, $3FFF/$4000, $BFFF/$C000, $FEFF/$FF00 and $FF04/$FF05. Directed sequences first visit the alias, boundary and swap cases on purpose.

// File: rtl/mmu_bank_map.sv
module mmu_bank_map #(
  parameter logic [7:0] CFG_RST = 8'h3C,
  parameter logic [7:0] ZP_RST  = 8'h00,
  parameter logic [7:0] SP_RST  = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_we,
  output logic [7:0]  cpu_rdata,
  output logic        reg_sel,
  output logic        ram_en,
  output logic        ram_bank,
  output logic [15:0] ram_addr,
  output logic        rom_lo_en,
  output logic        rom_mid_en,
  output logic        rom_hi_en,
  output logic        io_en,
  input  logic [13:0] vid_addr,
  output logic        vid_bank,
  output logic [15:0] vid_ram_addr
);
  localparam logic [7:0] TOP_PAGE = 8'hFF;
  localparam int         NREG     = 5;

  logic [7:0] cfg_q, shr_q, zp_q, sp_q, vid_q;
  logic [7:0] pg, tpg, bot_lim, top_base;
  logic       shared;

  function automatic logic [7:0] size_pages(input logic [1:0] sz);
    case (sz)
      2'd0:    return 8'd4;
      2'd1:    return 8'd16;
      2'd2:    return 8'd32;
      default: return 8'd64;
    endcase
  endfunction

  assign reg_sel = (cpu_addr[15:8] == TOP_PAGE) && (cpu_addr[7:0] < 8'(NREG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      shr_q <= 8'h00;
      zp_q  <= ZP_RST;
      sp_q  <= SP_RST;
      vid_q <= 8'h00;
    end else if (cpu_we && reg_sel) begin
      case (cpu_addr[2:0])
        3'd0:    cfg_q <= cpu_wdata;
        3'd1:    shr_q <= cpu_wdata;
        3'd2:    zp_q  <= cpu_wdata;
        3'd3:    sp_q  <= cpu_wdata;
        default: vid_q <= cpu_wdata;
      endcase
    end
  end

  always_comb begin
    cpu_rdata = 8'h00;
    if (reg_sel)
      case (cpu_addr[2:0])
        3'd0:    cpu_rdata = cfg_q;
        3'd1:    cpu_rdata = shr_q;
        3'd2:    cpu_rdata = zp_q;
        3'd3:    cpu_rdata = sp_q;
        default: cpu_rdata = vid_q;
      endcase
  end

  assign pg = cpu_addr[15:8];
  always_comb begin
    if (pg == 8'h00)      tpg = zp_q;
    else if (pg == zp_q)  tpg = 8'h00;
    else if (pg == 8'h01) tpg = sp_q;
    else if (pg == sp_q)  tpg = 8'h01;
    else                  tpg = pg;
  end
  assign ram_addr = {tpg, cpu_addr[7:0]};

  assign bot_lim  = shr_q[4] ? size_pages(shr_q[1:0]) : 8'd4;
  assign top_base = shr_q[5] ? 8'(9'd256 - {1'b0, size_pages(shr_q[3:2])}) : TOP_PAGE;
  assign shared   = (tpg < bot_lim) || (tpg >= top_base);
  assign ram_bank = cfg_q[0] ^ shared;

  assign io_en      = !reg_sel && cfg_q[2] && (cpu_addr[15:12] == 4'hD);
  assign rom_lo_en  = !reg_sel && cfg_q[3] && (cpu_addr[15:14] == 2'b01);
  assign rom_mid_en = !reg_sel && cfg_q[4] && (cpu_addr[15:14] == 2'b10);
  assign rom_hi_en  = !reg_sel && !io_en && cfg_q[5] && (cpu_addr[15:14] == 2'b11)
                      && (pg != TOP_PAGE);
  assign ram_en     = !(reg_sel || io_en || rom_lo_en || rom_mid_en || rom_hi_en);

  assign vid_bank     = vid_q[0];
  assign vid_ram_addr = {vid_q[3:2], vid_addr};
endmodule

module mmu_bank_map_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_we,
  input logic        reg_sel,
  input logic        ram_en,
  input logic        ram_bank,
  input logic [15:0] ram_addr,
  input logic        rom_lo_en,
  input logic        rom_mid_en,
  input logic        rom_hi_en,
  input logic        io_en,
  input logic [13:0] vid_addr,
  input logic [15:0] vid_ram_addr,
  input logic [7:0]  cfg_q
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_sel, ram_en, rom_lo_en, rom_mid_en, rom_hi_en, io_en}) == 1); // R7
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'hFF00) |=> (cfg_q == $past(cpu_wdata))); // R2
  AST_REG_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> !ram_en); // R2
  AST_MID_UNSHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_addr[15:8] >= 8'h40 && ram_addr[15:8] < 8'hC0) |-> (ram_bank == cfg_q[0])); // R3
  AST_BOT_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_addr[15:8] < 8'h04) |-> (ram_bank != cfg_q[0])); // R4
  AST_TOP_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_addr[15:8] == 8'hFF) |-> (ram_bank != cfg_q[0])); // R5
  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> (cpu_addr[15:12] == 4'hD)); // R6
  AST_VID_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    vid_ram_addr[13:0] == vid_addr); // R9
endmodule

bind mmu_bank_map mmu_bank_map_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
  .reg_sel(reg_sel), .ram_en(ram_en), .ram_bank(ram_bank), .ram_addr(ram_addr),
  .rom_lo_en(rom_lo_en), .rom_mid_en(rom_mid_en), .rom_hi_en(rom_hi_en), .io_en(io_en),
  .vid_addr(vid_addr), .vid_ram_addr(vid_ram_addr), .cfg_q(cfg_q)
);

// File: tb/mmu_bank_map_tb_top.sv
module mmu_bank_map_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic [13:0] vid_addr = 14'h0000;
  logic [7:0]  cpu_rdata;
  logic        reg_sel, ram_en, ram_bank, rom_lo_en, rom_mid_en, rom_hi_en, io_en, vid_bank;
  logic [15:0] ram_addr, vid_ram_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] m_cfg, m_shr, m_zp, m_sp, m_vid;

  always #2.5 clk = ~clk;

  mmu_bank_map dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .cpu_rdata(cpu_rdata), .reg_sel(reg_sel), .ram_en(ram_en), .ram_bank(ram_bank),
    .ram_addr(ram_addr), .rom_lo_en(rom_lo_en), .rom_mid_en(rom_mid_en),
    .rom_hi_en(rom_hi_en), .io_en(io_en), .vid_addr(vid_addr), .vid_bank(vid_bank),
    .vid_ram_addr(vid_ram_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, cpu_addr, act, exp);
    end
  endtask

  function automatic logic [7:0] pages_of(input logic [1:0] s);
    return 8'd4 << (s == 2'd0 ? 0 : s + 1);
  endfunction

  // {reg, io, lo, mid, hi, ram, bank, addr}
  function automatic logic [22:0] expect_of(input logic [15:0] a);
    logic [7:0] p, t, blim, tbase;
    logic r, io, lo, mid, hi, ram, sh;
    p = a[15:8];
    r   = (a >= 16'hFF00) && (a <= 16'hFF04);
    io  = !r && m_cfg[2] && (a >= 16'hD000) && (a <= 16'hDFFF);
    lo  = !r && m_cfg[3] && (a >= 16'h4000) && (a <= 16'h7FFF);
    mid = !r && m_cfg[4] && (a >= 16'h8000) && (a <= 16'hBFFF);
    hi  = !r && !io && m_cfg[5] && (a >= 16'hC000) && (a <= 16'hFEFF);
    ram = !(r | io | lo | mid | hi);
    if (p == 8'h00) t = m_zp;
    else if (p == m_zp) t = 8'h00;
    else if (p == 8'h01) t = m_sp;
    else if (p == m_sp) t = 8'h01;
    else t = p;
    blim  = m_shr[4] ? pages_of(m_shr[1:0]) : 8'd4;
    tbase = m_shr[5] ? 8'(16'd256 - 16'(pages_of(m_shr[3:2]))) : 8'hFF;
    sh = (t < blim) || (t >= tbase);
    return {r, io, lo, mid, hi, ram, m_cfg[0] ^ sh, t, a[7:0]};
  endfunction

  task automatic probe(input logic [15:0] a, input string req);
    logic [22:0] e;
    @(negedge clk);
    cpu_addr = a;
    #1;
    e = expect_of(a);
    chk(req, 32'({reg_sel, io_en, rom_lo_en, rom_mid_en, rom_hi_en, ram_en}), 32'(e[22:17]));
    chk("R7", 32'($countones({reg_sel, io_en, rom_lo_en, rom_mid_en, rom_hi_en, ram_en})), 32'd1);
    if (e[17]) begin
      chk(req, 32'(ram_bank), 32'(e[16]));
      chk(req, 32'(ram_addr), 32'(e[15:0]));
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = 16'hFF00 | 16'(r);
    cpu_wdata = d;
    cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    case (r)
      3'd0: m_cfg = d;
      3'd1: m_shr = d;
      3'd2: m_zp = d;
      3'd3: m_sp = d;
      default: m_vid = d;
    endcase
  endtask

  task automatic rd(input logic [2:0] r, input logic [7:0] e, input string req);
    @(negedge clk);
    cpu_addr = 16'hFF00 | 16'(r);
    #1;
    chk(req, 32'(reg_sel), 32'd1);
    chk(req, 32'(cpu_rdata), 32'(e));
  endtask

  task automatic vchk(input logic [13:0] va, input logic eb, input logic [15:0] ea);
    @(negedge clk);
    vid_addr = va;
    #1;
    chk("R9", 32'(vid_bank), 32'(eb));
    chk("R9", 32'(vid_ram_addr), 32'(ea));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [12];
    logic [7:0]  wd;
    logic [2:0]  wr_sel;
    void'($urandom(32'd20240611));
    edges = '{16'h03FF, 16'h0400, 16'h3FFF, 16'h4000, 16'hBFFF, 16'hC000,
              16'hCFFF, 16'hD000, 16'hFEFF, 16'hFF00, 16'hFF04, 16'hFF05};
    m_cfg = 8'h3C; m_shr = 8'h00; m_zp = 8'h00; m_sp = 8'h01; m_vid = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd0, 8'h3C, "R1"); rd(3'd1, 8'h00, "R1"); rd(3'd2, 8'h00, "R1");
    rd(3'd3, 8'h01, "R1"); rd(3'd4, 8'h00, "R1");
    probe(16'hFF05, "R2");
    probe(16'hFF03, "R2");

    wr(3'd0, 8'h02); rd(3'd0, 8'h02, "R2");
    probe(16'h5000, "R3");
    wr(3'd0, 8'h03); probe(16'h5000, "R3");
    chk("R3", 32'(ram_bank), 32'd1);

    wr(3'd0, 8'h00);
    probe(16'h03FF, "R4"); chk("R4", 32'(ram_bank), 32'd1);
    probe(16'h0400, "R4"); chk("R4", 32'(ram_bank), 32'd0);
    wr(3'd1, 8'h13);
    probe(16'h3FFF, "R4"); chk("R4", 32'(ram_bank), 32'd1);
    probe(16'h4000, "R4"); chk("R4", 32'(ram_bank), 32'd0);

    wr(3'd1, 8'h00);
    probe(16'hFF10, "R5"); chk("R5", 32'(ram_bank), 32'd1);
    probe(16'hFEFF, "R5"); chk("R5", 32'(ram_bank), 32'd0);
    wr(3'd1, 8'h24);
    probe(16'hF000, "R5"); chk("R5", 32'(ram_bank), 32'd1);
    probe(16'hEFFF, "R5"); chk("R5", 32'(ram_bank), 32'd0);

    wr(3'd0, 8'h3C);
    probe(16'hD000, "R6"); chk("R6", 32'(io_en), 32'd1);
    probe(16'hC000, "R6"); chk("R6", 32'(rom_hi_en), 32'd1);
    probe(16'h4000, "R6"); probe(16'h8000, "R6"); probe(16'h3FFF, "R6");
    wr(3'd0, 8'h38); probe(16'hD800, "R6"); chk("R6", 32'(rom_hi_en), 32'd1);
    wr(3'd0, 8'h04); probe(16'hC000, "R6"); chk("R6", 32'(ram_en), 32'd1);

    wr(3'd1, 8'h00); wr(3'd2, 8'h20);
    probe(16'h0005, "R8"); chk("R8", 32'(ram_addr), 32'h2005);
    probe(16'h2005, "R8"); chk("R8", 32'(ram_addr), 32'h0005);
    wr(3'd3, 8'h30);
    probe(16'h0100, "R8"); chk("R8", 32'(ram_addr), 32'h3000);
    probe(16'h3042, "R8"); chk("R8", 32'(ram_addr), 32'h0142);

    wr(3'd4, 8'h0E); vchk(14'h1234, 1'b0, 16'hD234);
    wr(3'd4, 8'h05); vchk(14'h1234, 1'b1, 16'h5234);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) begin
        wr_sel = 3'($urandom_range(4));
        wd = 8'($urandom);
        wr(wr_sel, wd);
        rd(wr_sel, wd, "R2");
        if (wr_sel == 3'd4) begin
          wd = 8'($urandom);
          vchk(14'(wd * 57), m_vid[0], {m_vid[3:2], 14'(wd * 57)});
        end
      end else if ($urandom_range(1) == 0) begin
        probe(edges[$urandom_range(11)], "R6");
      end else begin
        probe(16'($urandom), "R8");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule